// File: doc/BRIEF.md
# Spread-Spectrum Divider Modulator

This block produces the feedback divider value for a clock synthesizer whose output spectrum is to be spread. The integer divider M is offset by a triangular waveform. The offset advances only on a reference-tick strobe, so the block acts as a digital sequence generator paced by the reference clock. The result is a signed fixed-point divider value with 18 fractional bits. A loop filter and phase detector elsewhere would consume it.

The modulation rate comes from a mantissa and a power-of-two exponent, and the slope comes from an integer-plus-fraction step. In centre mode the offset swings to the same peak on both sides of M. In downspread mode the offset stays at or below M and reaches twice the peak. An acknowledge output is high exactly while modulation is active. After enable drops, the block keeps going until the running triangle is complete, so the average divider value is preserved. A range flag warns when the swing would push the divider outside its legal window. Configuration is captured only at the start of each triangle.

Top module: `divspread_mod`

## Requirements
- R1: After reset, `ack` is 0 and `mod_m` equals `m_in` × 2^18 (zero offset).
- R2: While idle, a `tick` with `en`=1 and `mant`≠0 starts modulation. After that tick, `ack`=1 and the offset is 0. A zero mantissa never starts modulation.
- R3: One triangle lasts exactly 4 × mant × 2^expo ticks. With `en` held high, the next triangle follows with no gap.
- R4: Centre mode (`down`=0): the step is `step_int`×2^18+`step_frac` in units of 2^-18. Let Q = mant × 2^min(expo,3) be the number of steps per quarter. The offset rises for Q steps to +ΔM = Q×step, falls for 2Q steps to −ΔM, then rises for Q steps back to 0. `mod_m` is the two's-complement value M×2^18 + offset.
- R5: When expo > 3, a step is taken only on every 2^(expo−3)-th tick of the triangle. The offset holds on the other ticks.
- R6: Downspread mode (`down`=1): the offset falls for 2Q steps to −2ΔM, then rises for 2Q steps to 0. It is never positive.
- R7: If `en` is low when a triangle completes, the offset is exactly 0 on that tick and `ack` falls after it. Dropping `en` mid-triangle does not shorten the triangle.
- R8: `m_in`, `mant`, `expo`, `down` and the step are sampled only when a triangle starts. Changes in mid-triangle do not alter `mod_m`.
- R9: The offset changes only on clock edges where `tick`=1.
- R10: `range_err`=1 unless M×2^18 − ΔM ≥ 20×2^18 and M×2^18 + ΔM ≤ 2045×2^18 (centre mode), or unless M×2^18 − 2ΔM ≥ 20×2^18 and M ≤ 2045 (downspread mode). It is evaluated on the captured configuration while `ack`=1 and on the live inputs otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference-tick strobe, one clock wide |
| en | input | 1 | Modulation enable |
| down | input | 1 | 1 = downspread, 0 = centre spread |
| m_in | input | 11 | Integer feedback divider M |
| mant | input | 7 | Rate divider mantissa |
| expo | input | 3 | Rate divider exponent |
| step_int | input | 2 | Step integer part |
| step_frac | input | 18 | Step fraction part |
| mod_m | output | 33 | Modulated divider, signed, 18 fractional bits |
| ack | output | 1 | Modulation active |
| range_err | output | 1 | Divider swing outside the legal window |

## Verification
The hardest situation to reach is a triangle with an exponent above 3. In that case the step pacing and the quarter boundaries interleave, and enable drops or the configuration inputs change while the triangle is still running. The stimulus sweeps mantissa, exponent and mode over a small grid, ticking every triangle to completion. In selected runs, every configuration input is disturbed on the second tick and enable is released early. The expected offset is recomputed from the tick index and compared after every tick. Idle gaps between ticks check that the offset holds.

// File: rtl/divspread_pkg.sv
package divspread_pkg;
  typedef logic [47:0] calc_t;

  // steps per quarter: mantissa scaled by 2^min(exponent,3)
  function automatic calc_t peak_steps(calc_t mant, calc_t ex);
    return (ex > calc_t'(3)) ? (mant << 3) : (mant << ex);
  endfunction

  // ticks between steps, minus one
  function automatic calc_t pace_last(calc_t ex);
    return (ex > calc_t'(3)) ? ((calc_t'(1) << (ex - calc_t'(3))) - calc_t'(1)) : '0;
  endfunction

  function automatic calc_t peak_delta(calc_t mant, calc_t ex, calc_t step);
    return peak_steps(mant, ex) * step;
  endfunction

  // direction of a quarter: centre rises in 0 and 3, downspread rises in 2 and 3
  function automatic logic quarter_rises(logic [1:0] q, logic down);
    if (down) return q[1];
    return (q == 2'd0) || (q == 2'd3);
  endfunction

  function automatic logic spread_fits(calc_t m, calc_t dm, logic down, int frac_w,
                                       int lo_lim, int hi_lim);
    calc_t ms, lo, hi;
    ms = m << frac_w;
    lo = calc_t'(lo_lim) << frac_w;
    hi = calc_t'(hi_lim) << frac_w;
    if (down) return (ms >= lo + (dm << 1)) && (ms <= hi);
    return (ms >= lo + dm) && (ms + dm <= hi);
  endfunction
endpackage

// File: rtl/divspread_pace.sv
module divspread_pace
  import divspread_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [EXP_W-1:0] ex,
  output logic             stb
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim = CNT_W'(pace_last(calc_t'(ex)));
  assign stb = adv && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= '0;
    else if (adv)    cnt_q <= (cnt_q == lim) ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/divspread_ramp.sv
module divspread_ramp
  import divspread_pkg::*;
#(
  parameter int Q_W    = 10,
  parameter int STEP_W = 20,
  parameter int OFS_W  = 33
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    stb,
  input  logic                    down,
  input  logic [Q_W-1:0]          q_steps,
  input  logic [STEP_W-1:0]       step,
  output logic signed [OFS_W-1:0] ofs,
  output logic signed [OFS_W-1:0] ofs_next,
  output logic                    last
);
  logic [Q_W-1:0]          sc_q;
  logic [1:0]              qtr_q;
  logic signed [OFS_W-1:0] ofs_q;
  logic signed [OFS_W-1:0] stepx;
  logic                    quarter_done;

  assign stepx        = $signed({{(OFS_W-STEP_W){1'b0}}, step});
  assign ofs_next     = quarter_rises(qtr_q, down) ? ofs_q + stepx : ofs_q - stepx;
  assign quarter_done = (sc_q == q_steps - Q_W'(1));
  assign last         = stb && quarter_done && (qtr_q == 2'd3);
  assign ofs          = ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      ofs_q <= '0;
      sc_q  <= '0;
      qtr_q <= 2'd0;
    end else if (stb) begin
      ofs_q <= ofs_next;
      if (quarter_done) begin
        sc_q  <= '0;
        qtr_q <= qtr_q + 2'd1;
      end else begin
        sc_q  <= sc_q + Q_W'(1);
      end
    end
  end
endmodule

// File: rtl/divspread_limit.sv
module divspread_limit
  import divspread_pkg::*;
#(
  parameter int M_W    = 11,
  parameter int MANT_W = 7,
  parameter int EXP_W  = 3,
  parameter int STEP_W = 20,
  parameter int SF_W   = 18,
  parameter int OFS_W  = 33,
  parameter int LO_LIM = 20,
  parameter int HI_LIM = 2045
) (
  input  logic [M_W-1:0]    m,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  ex,
  input  logic [STEP_W-1:0] step,
  input  logic              down,
  output logic [OFS_W-1:0]  dm,
  output logic              range_err
);
  calc_t dm_c;

  assign dm_c      = peak_delta(calc_t'(mant), calc_t'(ex), calc_t'(step));
  assign dm        = OFS_W'(dm_c);
  assign range_err = !spread_fits(calc_t'(m), dm_c, down, SF_W, LO_LIM, HI_LIM);
endmodule

// File: rtl/divspread_mod.sv
module divspread_mod
  import divspread_pkg::*;
#(
  parameter int M_W    = 11,
  parameter int MANT_W = 7,
  parameter int EXP_W  = 3,
  parameter int SI_W   = 2,
  parameter int SF_W   = 18,
  parameter int OFS_IW = 14,
  parameter int LO_LIM = 20,
  parameter int HI_LIM = 2045
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   en,
  input  logic                   down,
  input  logic [M_W-1:0]         m_in,
  input  logic [MANT_W-1:0]      mant,
  input  logic [EXP_W-1:0]       expo,
  input  logic [SI_W-1:0]        step_int,
  input  logic [SF_W-1:0]        step_frac,
  output logic [OFS_IW+SF_W:0]   mod_m,
  output logic                   ack,
  output logic                   range_err
);
  localparam int STEP_W = SI_W + SF_W;
  localparam int Q_W    = MANT_W + 3;
  localparam int OFS_W  = OFS_IW + SF_W + 1;
  localparam int PACE_W = ((1 << EXP_W) > 4) ? (1 << EXP_W) - 3 : 1;

  logic                    run_q;
  logic [M_W-1:0]          cm_q;
  logic [MANT_W-1:0]       cmant_q;
  logic [EXP_W-1:0]        cexp_q;
  logic [STEP_W-1:0]       cstep_q;
  logic                    cdown_q;

  logic [STEP_W-1:0]       live_step;
  logic                    start_evt;
  logic                    keep_on;
  logic                    adv;
  logic                    reload;
  logic                    step_stb;
  logic                    cyc_end_w;
  logic [Q_W-1:0]          q_steps;
  logic signed [OFS_W-1:0] ofs_w;
  logic signed [OFS_W-1:0] ofs_next_w;
  logic signed [OFS_W-1:0] base_w;

  logic [M_W-1:0]          act_m;
  logic [MANT_W-1:0]       act_mant;
  logic [EXP_W-1:0]        act_exp;
  logic [STEP_W-1:0]       act_step;
  logic                    act_down;
  logic [OFS_W-1:0]        dm_act;

  assign live_step = {step_int, step_frac};
  assign keep_on   = en && (mant != '0);
  assign start_evt = tick && !run_q && keep_on;
  assign adv       = tick && run_q;
  assign reload    = start_evt || (cyc_end_w && keep_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cm_q    <= '0;
      cmant_q <= '0;
      cexp_q  <= '0;
      cstep_q <= '0;
      cdown_q <= 1'b0;
    end else begin
      if (start_evt)                  run_q <= 1'b1;
      else if (cyc_end_w && !keep_on) run_q <= 1'b0;
      if (reload) begin
        cm_q    <= m_in;
        cmant_q <= mant;
        cexp_q  <= expo;
        cstep_q <= live_step;
        cdown_q <= down;
      end
    end
  end

  assign q_steps = Q_W'(peak_steps(calc_t'(cmant_q), calc_t'(cexp_q)));

  divspread_pace #(.EXP_W(EXP_W), .CNT_W(PACE_W)) u_pace (
    .clk  (clk),
    .rst_n(rst_n),
    .load (reload),
    .adv  (adv),
    .ex   (cexp_q),
    .stb  (step_stb)
  );

  divspread_ramp #(.Q_W(Q_W), .STEP_W(STEP_W), .OFS_W(OFS_W)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (reload),
    .stb     (step_stb),
    .down    (cdown_q),
    .q_steps (q_steps),
    .step    (cstep_q),
    .ofs     (ofs_w),
    .ofs_next(ofs_next_w),
    .last    (cyc_end_w)
  );

  assign act_m    = run_q ? cm_q    : m_in;
  assign act_mant = run_q ? cmant_q : mant;
  assign act_exp  = run_q ? cexp_q  : expo;
  assign act_step = run_q ? cstep_q : live_step;
  assign act_down = run_q ? cdown_q : down;

  divspread_limit #(
    .M_W(M_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .STEP_W(STEP_W), .SF_W(SF_W),
    .OFS_W(OFS_W), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM)
  ) u_limit (
    .m        (act_m),
    .mant     (act_mant),
    .ex       (act_exp),
    .step     (act_step),
    .down     (act_down),
    .dm       (dm_act),
    .range_err(range_err)
  );

  assign base_w = $signed({{(OFS_W-M_W-SF_W){1'b0}}, act_m, {SF_W{1'b0}}});
  assign mod_m  = base_w + ofs_w;
  assign ack    = run_q;
endmodule

// File: rtl/divspread_chk.sv
module divspread_chk #(
  parameter int OFS_W = 33
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    en,
  input logic                    ack,
  input logic                    down_act,
  input logic                    cyc_end,
  input logic signed [OFS_W-1:0] ofs,
  input logic signed [OFS_W-1:0] ofs_next,
  input logic [OFS_W-1:0]        dm
);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (ofs == '0));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(tick && en) && (ofs == '0)));

  // R4
  centre_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !down_act) |-> ((ofs <= $signed(dm)) && (ofs >= -$signed(dm))));

  // R6
  down_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && down_act) |-> ((ofs[OFS_W-1] || (ofs == '0)) && (ofs >= -($signed(dm) <<< 1))));

  // R7
  cycle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> (ofs_next == '0));

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !en) |=> !ack);

  // R9
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ofs));
endmodule

bind divspread_mod divspread_chk #(.OFS_W(OFS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .en      (en),
  .ack     (ack),
  .down_act(act_down),
  .cyc_end (cyc_end_w),
  .ofs     (ofs_w),
  .ofs_next(ofs_next_w),
  .dm      (dm_act)
);

// File: tb/divspread_mod_bench.sv
`timescale 1ns/1ps
module divspread_mod_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic        down = 1'b0;
  logic [10:0] m_in = 11'd1000;
  logic [6:0]  mant = 7'd0;
  logic [2:0]  expo = 3'd0;
  logic [1:0]  step_int = 2'd0;
  logic [17:0] step_frac = 18'd0;
  logic signed [32:0] mod_m;
  logic        ack;
  logic        range_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divspread_mod u_divspread_mod (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .down(down), .m_in(m_in),
    .mant(mant), .expo(expo), .step_int(step_int), .step_frac(step_frac),
    .mod_m(mod_m), .ack(ack), .range_err(range_err)
  );

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic longint model_ofs(longint t, longint mn, longint ex, longint st, bit dn);
    longint p, q, s;
    p = (ex > 3) ? (longint'(1) << (ex - 3)) : 1;
    q = mn * ((ex > 3) ? 8 : (longint'(1) << ex));
    s = t / p;
    if (dn) return (s <= 2*q) ? -s*st : (s - 4*q)*st;
    if (s <= q) return s*st;
    if (s <= 3*q) return (2*q - s)*st;
    return (s - 4*q)*st;
  endfunction

  function automatic bit model_err(longint m, longint mn, longint ex, longint st, bit dn);
    longint dm, ms, lo, hi;
    dm = mn * ((ex > 3) ? 8 : (longint'(1) << ex)) * st;
    ms = m * 262144; lo = 20 * 262144; hi = 2045 * 262144;
    if (dn) return !((ms >= lo + 2*dm) && (m <= 2045));
    return !((ms >= lo + dm) && (ms + dm <= hi));
  endfunction

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_seq(int m, int mn, int ex, int si, int sf, bit dn, int ncyc, bit disturb);
    longint st, len, tt, expv, m_live;
    st = longint'(si) * 262144 + sf;
    len = 4 * longint'(mn) * (longint'(1) << ex);
    m_live = m;
    m_in = 11'(m); mant = 7'(mn); expo = 3'(ex); step_int = 2'(si);
    step_frac = 18'(sf); down = dn; en = 1'b1;
    pulse_tick();
    chk(ack == 1'b1, "R2", longint'(ack), 1);
    chk(mod_m == longint'(m) * 262144, "R2", mod_m, longint'(m) * 262144);
    for (longint t = 1; t <= ncyc * len; t++) begin
      if (t == (ncyc - 1) * len + 1) en = 1'b0;
      if (disturb && t == 2) begin
        m_live = m ^ 5; m_in = 11'(m_live); mant = 7'(mn + 1); expo = 3'(ex ^ 1);
        down = !dn; step_frac = 18'(sf ^ 1);
      end
      pulse_tick();
      tt = ((t - 1) % len) + 1;
      if (t == ncyc * len) begin
        chk(ack == 1'b0, "R7", longint'(ack), 0);
        chk(mod_m == m_live * 262144, "R7", mod_m, m_live * 262144);
      end else begin
        expv = longint'(m) * 262144 + model_ofs(tt, mn, ex, st, dn);
        chk(ack == 1'b1, "R3", longint'(ack), 1);
        chk(mod_m == expv, disturb ? "R8" : (ex > 3 ? "R5" : (dn ? "R6" : "R4")), mod_m, expv);
        chk(range_err == model_err(m, mn, ex, st, dn), "R10", longint'(range_err),
            longint'(model_err(m, mn, ex, st, dn)));
        if (t % 5 == 0) begin
          repeat (2) @(negedge clk);
          chk(mod_m == expv, "R9", mod_m, expv);
        end
      end
    end
  endtask

  task automatic err_case(int m, int mn, int ex, int si, int sf, bit dn);
    bit e;
    m_in = 11'(m); mant = 7'(mn); expo = 3'(ex); step_int = 2'(si);
    step_frac = 18'(sf); down = dn;
    @(negedge clk);
    e = model_err(m, mn, ex, longint'(si) * 262144 + sf, dn);
    chk(range_err == e, "R10", longint'(range_err), longint'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ack == 1'b0, "R1", longint'(ack), 0);
    chk(mod_m == 1000 * 262144, "R1", mod_m, 1000 * 262144);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack == 1'b0, "R1", longint'(ack), 0);

    // R2: zero mantissa never starts
    en = 1'b1; mant = 7'd0; m_in = 11'd500;
    repeat (3) pulse_tick();
    chk(ack == 1'b0, "R2", longint'(ack), 0);
    chk(mod_m == 500 * 262144, "R2", mod_m, 500 * 262144);
    en = 1'b0;
    pulse_tick();

    // sweep over mantissa, exponent and mode (R3 R4 R5 R6 R7 R9 R10)
    for (int mn = 1; mn <= 3; mn += 2)
      for (int ex = 0; ex <= 5; ex++)
        for (int dn = 0; dn <= 1; dn++)
          run_seq(1000, mn, ex, 1, 12345 * (ex + 1), bit'(dn), 1, 1'b0);

    // back-to-back triangles, enable dropped in the last one (R3 R7)
    run_seq(700, 2, 4, 0, 99999, 1'b0, 3, 1'b0);
    run_seq(700, 1, 2, 3, 1, 1'b1, 2, 1'b0);
    // configuration disturbed mid-triangle (R8)
    run_seq(900, 2, 5, 1, 777, 1'b0, 1, 1'b1);
    run_seq(900, 3, 1, 2, 4321, 1'b1, 1, 1'b1);

    // R10 boundaries with delta M = 1.0
    err_case(21, 1, 0, 1, 0, 1'b0);
    err_case(20, 1, 0, 1, 0, 1'b0);
    err_case(2044, 1, 0, 1, 0, 1'b0);
    err_case(2045, 1, 0, 1, 0, 1'b0);
    err_case(22, 1, 0, 1, 0, 1'b1);
    err_case(21, 1, 0, 1, 0, 1'b1);
    err_case(2045, 1, 0, 1, 0, 1'b1);
    err_case(2046, 1, 0, 1, 0, 1'b1);
    for (int m = 15; m <= 2047; m += 97)
      for (int ex = 2; ex <= 6; ex += 2)
        for (int dn = 0; dn <= 1; dn++)
          err_case(m, 5, ex, 1, 200000, bit'(dn));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule